// File: doc/BRIEF.md
# MIDI host interface controller

This block sits between a legacy host bus and a MIDI byte UART. It offers the host two byte-wide ports behind a decoded chip select: a data port and a combined status/command port. Host accesses use active-low read and write strobes sampled on the block clock. An interrupt line tells the host that a received byte is waiting.

Only the pass-through (UART) mode is provided. After reset the block is in command mode, where it accepts only two commands: the enter-UART-mode command 3Fh and the reset command FFh. Both answer with an acknowledge byte FEh in the receive register. In UART mode every data byte moves unchanged between host and UART through one-byte holding registers with valid/ready handshakes. The only command still honoured there is FFh, which drops back to command mode and flushes any pending receive byte. The serializer, the baud generator and any configuration registers sit outside the block.

Top module: `midi_host_if`

## Requirements
- R1: After reset the block is in command mode. A status read (address bit 1) returns 80h, irq_o is low, tx_valid_o is low and rx_ready_o is low.
- R2: In command mode, writing 3Fh to the command port (address 1) enters UART mode, loads FEh as a pending receive byte and raises irq_o. Status bit 7 (receive empty) then reads 0.
- R3: In command mode, writing FFh to the command port keeps command mode and loads FEh as a pending receive byte.
- R4: In command mode, any command byte other than 3Fh and FFh is ignored, with no acknowledge and no mode change. Data-port writes are dropped (tx_valid_o stays low) and rx_ready_o stays low.
- R5: In UART mode, a write to the data port (address 0) presents the same byte on tx_data_o with tx_valid_o high. The byte is held unchanged until tx_ready_i is sampled high.
- R6: Status bit 6 reads 1 while a transmit byte is pending. A data write while one is pending is dropped, unless tx_ready_i drains the pending byte in that same cycle, in which case the new byte is taken.
- R7: In UART mode with no byte pending, rx_ready_o is high and a byte offered with rx_valid_o... rx_valid_i is captured unchanged. irq_o stays high and status bit 7 reads 0 until a data-port read ends (read strobe released), which clears both.
- R8: In UART mode, every command byte except FFh (3Fh included) is ignored, with no acknowledge and no mode change.
- R9: In UART mode, FFh returns to command mode and flushes the pending receive byte without an acknowledge. A receive byte handshaked in that same cycle is discarded.
- R10: Status bits 5 to 0 always read 0. The data port returns the receive holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | block clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| cs_i | input | 1 | decoded chip select for the two ports |
| addr_i | input | 1 | 0 = data port, 1 = status/command port |
| rd_ni | input | 1 | host read strobe, active low |
| wr_ni | input | 1 | host write strobe, active low |
| wdata_i | input | 8 | host write data |
| rdata_o | output | 8 | host read data |
| irq_o | output | 1 | receive byte pending interrupt |
| tx_data_o | output | 8 | byte to the UART transmitter |
| tx_valid_o | output | 1 | transmit byte valid |
| tx_ready_i | input | 1 | UART accepts the transmit byte |
| rx_data_i | input | 8 | byte from the UART receiver |
| rx_valid_i | input | 1 | receive byte valid |
| rx_ready_o | output | 1 | block accepts a receive byte |

## Verification
Two pairs of events can share a cycle. In the first, a host data write lands in the cycle where the UART drains the pending transmit byte. In the second, the FFh command lands in the cycle where a receive byte completes its handshake. The bench drives both edges on the same falling clock edge. For the first pair it expects the new byte on tx_data_o. For the second it expects an empty receive side, a low interrupt and command mode. All 256 byte values are swept through both data paths, and all command values are swept in both modes.

// File: rtl/midi_pkg.sv
package midi_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic {MODE_CMD = 1'b0, MODE_UART = 1'b1} mode_e;
  localparam byte_t CMD_ENTER_UART = 8'h3F;
  localparam byte_t CMD_RESET      = 8'hFF;
  localparam byte_t ACK_BYTE       = 8'hFE;
  localparam int unsigned ST_TX_BUSY  = 6;
  localparam int unsigned ST_RX_EMPTY = 7;
endpackage

// File: rtl/midi_strobe.sv
module midi_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic addr_i,
  input  logic rd_ni,
  input  logic wr_ni,
  output logic dat_wr_o,
  output logic cmd_wr_o,
  output logic dat_rd_done_o
);
  logic wr_q, rd_q, rd_cs_q, rd_addr_q, wr_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q      <= 1'b1;
      rd_q      <= 1'b1;
      rd_cs_q   <= 1'b0;
      rd_addr_q <= 1'b0;
    end else begin
      wr_q <= wr_ni;
      rd_q <= rd_ni;
      if (!rd_ni) begin
        rd_cs_q   <= cs_i;
        rd_addr_q <= addr_i;
      end
    end
  end

  // act once per write on the assertion edge; read side effect on release
  assign wr_fall       = wr_q && !wr_ni && cs_i;
  assign dat_wr_o      = wr_fall && !addr_i;
  assign cmd_wr_o      = wr_fall && addr_i;
  assign dat_rd_done_o = !rd_q && rd_ni && rd_cs_q && !rd_addr_q;
endmodule

// File: rtl/midi_cmd_ctrl.sv
module midi_cmd_ctrl
  import midi_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cmd_wr_i,
  input  byte_t cmd_i,
  output logic  uart_mode_o,
  output logic  ack_o,
  output logic  flush_o
);
  mode_e mode_q, mode_d;
  logic  is_rst, is_enter;

  assign is_rst   = cmd_i == CMD_RESET;
  assign is_enter = cmd_i == CMD_ENTER_UART;

  always_comb begin
    mode_d = mode_q;
    if (cmd_wr_i) begin
      if (is_rst)                            mode_d = MODE_CMD;
      else if (is_enter && mode_q == MODE_CMD) mode_d = MODE_UART;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_CMD;
    else         mode_q <= mode_d;
  end

  assign uart_mode_o = mode_q == MODE_UART;
  assign ack_o       = cmd_wr_i && mode_q == MODE_CMD && (is_rst || is_enter);
  assign flush_o     = cmd_wr_i && is_rst;

  assert_uart_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uart_mode_o && cmd_wr_i && cmd_i != CMD_RESET) |=> uart_mode_o);
  assert_rst_exits_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && cmd_i == CMD_RESET) |=> !uart_mode_o);
endmodule

// File: rtl/midi_rx_hold.sv
module midi_rx_hold
  import midi_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  ack_i,
  input  logic  flush_i,
  input  logic  pop_i,
  input  byte_t rx_data_i,
  input  logic  rx_valid_i,
  output logic  rx_ready_o,
  output logic  pend_o,
  output byte_t data_o
);
  logic  pend_q, take;
  byte_t data_q;

  assign rx_ready_o = en_i && !pend_q;
  assign take       = rx_valid_i && rx_ready_o;

  // priority: acknowledge, flush, capture, host pop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      data_q <= '0;
    end else if (ack_i) begin
      pend_q <= 1'b1;
      data_q <= ACK_BYTE;
    end else if (flush_i) begin
      pend_q <= 1'b0;
    end else if (take) begin
      pend_q <= 1'b1;
      data_q <= rx_data_i;
    end else if (pop_i) begin
      pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign data_o = data_q;

  assert_rx_capture_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !flush_i && !ack_i) |=> (pend_o && data_o == $past(rx_data_i)));
  assert_flush_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !ack_i) |=> !pend_o);
endmodule

// File: rtl/midi_tx_hold.sv
module midi_tx_hold
  import midi_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  wr_i,
  input  byte_t data_i,
  input  logic  tx_ready_i,
  output logic  tx_valid_o,
  output byte_t tx_data_o
);
  logic  valid_q, accept;
  byte_t data_q;

  // a write is taken if the slot is empty or drains in the same cycle
  assign accept = wr_i && en_i && (!valid_q || tx_ready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      data_q  <= data_i;
    end else if (tx_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign tx_valid_o = valid_q;
  assign tx_data_o  = data_q;

  assert_tx_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));
  assert_tx_cmd_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !tx_valid_o) |=> !tx_valid_o);
endmodule

// File: rtl/midi_host_if.sv
module midi_host_if
  import midi_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cs_i,
  input  logic        addr_i,
  input  logic        rd_ni,
  input  logic        wr_ni,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        irq_o,
  output logic [7:0]  tx_data_o,
  output logic        tx_valid_o,
  input  logic        tx_ready_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_valid_i,
  output logic        rx_ready_o
);
  logic  dat_wr, cmd_wr, dat_rd_done, uart_mode, ack, flush, rx_pend;
  byte_t rx_byte, status;

  midi_strobe i_strobe (
    .clk_i, .rst_ni, .cs_i, .addr_i, .rd_ni, .wr_ni,
    .dat_wr_o(dat_wr), .cmd_wr_o(cmd_wr), .dat_rd_done_o(dat_rd_done)
  );

  midi_cmd_ctrl i_cmd (
    .clk_i, .rst_ni, .cmd_wr_i(cmd_wr), .cmd_i(wdata_i),
    .uart_mode_o(uart_mode), .ack_o(ack), .flush_o(flush)
  );

  midi_rx_hold i_rx (
    .clk_i, .rst_ni, .en_i(uart_mode), .ack_i(ack), .flush_i(flush),
    .pop_i(dat_rd_done), .rx_data_i, .rx_valid_i, .rx_ready_o,
    .pend_o(rx_pend), .data_o(rx_byte)
  );

  midi_tx_hold i_tx (
    .clk_i, .rst_ni, .en_i(uart_mode), .wr_i(dat_wr), .data_i(wdata_i),
    .tx_ready_i, .tx_valid_o, .tx_data_o
  );

  always_comb begin
    status = '0;
    status[ST_RX_EMPTY] = !rx_pend;
    status[ST_TX_BUSY]  = tx_valid_o;
  end

  assign rdata_o = addr_i ? status : rx_byte;
  assign irq_o   = rx_pend;

  assert_no_rx_cmd_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i == CMD_RESET) |=> !rx_ready_o);
  assert_irq_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_rd_done && !rx_valid_i && !cmd_wr) |=> !irq_o);
endmodule

// File: tb/test_midi_host_if.sv
module test_midi_host_if;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       cs_i = 1'b0, addr_i = 1'b0, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [7:0] wdata_i = '0, rx_data_i = '0;
  logic       tx_ready_i = 1'b0, rx_valid_i = 1'b0;
  logic [7:0] rdata_o, tx_data_o;
  logic       irq_o, tx_valid_o, rx_ready_o;
  int         n_chk = 0, n_bad = 0;
  logic       done = 1'b0;

  always #5 clk = ~clk;

  midi_host_if i_midi_host_if (
    .clk_i(clk), .rst_ni, .cs_i, .addr_i, .rd_ni, .wr_ni, .wdata_i, .rdata_o,
    .irq_o, .tx_data_o, .tx_valid_o, .tx_ready_i, .rx_data_i, .rx_valid_i, .rx_ready_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic a, input logic [7:0] d);
    @(negedge clk); cs_i = 1'b1; addr_i = a; wdata_i = d; wr_ni = 1'b0;
    @(negedge clk); wr_ni = 1'b1; cs_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic host_rd(input logic a, output logic [7:0] d);
    @(negedge clk); cs_i = 1'b1; addr_i = a; rd_ni = 1'b0;
    #1 d = rdata_o;
    @(negedge clk); rd_ni = 1'b1; cs_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic rx_push(input logic [7:0] d);
    @(negedge clk); rx_valid_i = 1'b1; rx_data_i = d;
    @(negedge clk); rx_valid_i = 1'b0;
  endtask

  task automatic tx_drain();
    @(negedge clk); tx_ready_i = 1'b1;
    @(negedge clk); tx_ready_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    host_rd(1'b1, r);
    chk("R1 status", r, 8'h80);
    chk("R1 irq", irq_o, 0);
    chk("R1 tx_valid", tx_valid_o, 0);
    chk("R1 rx_ready", rx_ready_o, 0);

    // R4 command mode sweep of ignored commands, and dropped data writes
    for (int c = 0; c < 256; c++) begin
      if (c == 8'h3F || c == 8'hFF) continue;
      host_wr(1'b1, c[7:0]);
      chk("R4 no ack", irq_o, 0);
      chk("R4 mode kept", rx_ready_o, 0);
    end
    host_wr(1'b0, 8'hA5);
    chk("R4 data dropped", tx_valid_o, 0);
    rx_valid_i = 1'b1; rx_data_i = 8'h12;
    repeat (2) @(negedge clk);
    rx_valid_i = 1'b0;
    chk("R4 no rx in cmd mode", irq_o, 0);

    // R3 reset in command mode gives ack
    host_wr(1'b1, 8'hFF);
    chk("R3 irq", irq_o, 1);
    chk("R3 stays cmd", rx_ready_o, 0);
    host_rd(1'b0, r);
    chk("R3 ack byte", r, 8'hFE);
    chk("R3 irq cleared", irq_o, 0);

    // R2 enter UART mode
    host_wr(1'b1, 8'h3F);
    chk("R2 irq", irq_o, 1);
    host_rd(1'b1, r);
    chk("R2 status", r, 8'h00);
    host_rd(1'b0, r);
    chk("R2 ack byte", r, 8'hFE);
    chk("R2 uart mode", rx_ready_o, 1);
    host_rd(1'b1, r);
    chk("R10 status idle", r, 8'h80);

    // R8 command sweep in UART mode
    for (int c = 0; c < 255; c++) begin
      host_wr(1'b1, c[7:0]);
      chk("R8 no ack", irq_o, 0);
      chk("R8 mode kept", rx_ready_o, 1);
    end

    // R5 tx pass-through sweep
    for (int b = 0; b < 256; b++) begin
      host_wr(1'b0, b[7:0]);
      chk("R5 tx_valid", tx_valid_o, 1);
      chk("R5 tx_data", tx_data_o, b);
      host_rd(1'b1, r);
      chk("R6 busy status", r, 8'hC0);
      tx_drain();
      chk("R5 drained", tx_valid_o, 0);
    end

    // R6 write while busy dropped
    host_wr(1'b0, 8'h11);
    host_wr(1'b0, 8'h22);
    chk("R6 dropped keeps", tx_data_o, 8'h11);
    chk("R6 still valid", tx_valid_o, 1);
    // R6 write in drain cycle is taken
    @(negedge clk); tx_ready_i = 1'b1; cs_i = 1'b1; addr_i = 1'b0; wdata_i = 8'h33; wr_ni = 1'b0;
    @(negedge clk); tx_ready_i = 1'b0; wr_ni = 1'b1; cs_i = 1'b0;
    chk("R6 same-cycle valid", tx_valid_o, 1);
    chk("R6 same-cycle data", tx_data_o, 8'h33);
    tx_drain();
    chk("R6 idle", tx_valid_o, 0);

    // R7 rx pass-through sweep
    for (int b = 0; b < 256; b++) begin
      chk("R7 ready", rx_ready_o, 1);
      rx_push(b[7:0]);
      chk("R7 irq", irq_o, 1);
      chk("R7 not ready", rx_ready_o, 0);
      host_rd(1'b1, r);
      chk("R7 status pending", r, 8'h00);
      host_rd(1'b0, r);
      chk("R7 data", r, b);
      chk("R7 irq cleared", irq_o, 0);
    end

    // R9 reset in UART mode flushes pending, no ack
    rx_push(8'h5A);
    host_wr(1'b1, 8'hFF);
    chk("R9 flushed", irq_o, 0);
    chk("R9 cmd mode", rx_ready_o, 0);
    host_rd(1'b1, r);
    chk("R9 status", r, 8'h80);

    // R9 collision: FFh with rx handshake in same cycle
    host_wr(1'b1, 8'h3F);
    host_rd(1'b0, r);
    @(negedge clk); rx_valid_i = 1'b1; rx_data_i = 8'h55;
    cs_i = 1'b1; addr_i = 1'b1; wdata_i = 8'hFF; wr_ni = 1'b0;
    @(negedge clk); rx_valid_i = 1'b0; wr_ni = 1'b1; cs_i = 1'b0;
    chk("R9 collide irq", irq_o, 0);
    chk("R9 collide mode", rx_ready_o, 0);
    host_rd(1'b1, r);
    chk("R9 collide status", r, 8'h80);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule